// File: doc/BRIEF.md
# Remote Operand Buffer with Stack-Pointer Retention

This block lives inside one cluster of a partitioned superscalar core. It holds local copies of source operands whose producers execute in other clusters, so consumers in this cluster can read them without crossing the intercluster path again. The rename or steering stage claims an entry and gets back its index. The completing producer later fills the entry by index, and consumers read it through several independent read ports.

Two pools share one index space. The general pool holds `NGEN` entries, with indices 0 to NGEN-1. Each general entry serves a single registered consumer and is released once that consumer reads it.

Two further entries, at indices NGEN and NGEN+1, are kept for stack-pointer values. An entry in this pool is claimed as soon as a stack-pointer-defining instruction is renamed. Reads do not release it. It stays live until the next stack-pointer producer commits. A flush clears every general entry and any stack-pointer entry that has not yet committed, but it keeps the most recently committed stack-pointer value.

Top module: `remote_opnd_buf`

## Requirements
- R1: After reset every entry is free, every read port reports not-ready, and an allocation request is granted without stall.
- R2: An allocation (`alloc_pool` 0 = general, 1 = stack-pointer) is granted in the same cycle and returns the lowest free index of the requested pool: general indices 0..NGEN-1, stack-pointer indices NGEN and NGEN+1. The new entry is valid, not ready, and carries `alloc_ptag`.
- R3: An allocation to a pool with no free entry raises `alloc_stall` and gets no grant. The stall clears in the cycle after an entry of that pool is released.
- R4: Reading an entry that is valid but not yet written returns `rd_ready` = 0 and does not release the entry.
- R5: A completion write to a valid entry makes it ready with the written value from the next cycle. A write to a free entry has no effect.
- R6: A completion write and a read of the same valid entry in the same cycle return `rd_ready` = 1 and the value being written.
- R7: A general entry whose read returns `rd_ready` = 1 is free from the next cycle.
- R8: A stack-pointer entry stays ready with its value across any number of reads, including reads on several ports in one cycle.
- R9: Committing a stack-pointer entry (`cmt_en` with its index) releases the previously committed stack-pointer entry from the next cycle. A commit naming a general index has no effect.
- R10: `flush` frees all general entries and all uncommitted stack-pointer entries from the next cycle, and keeps the committed stack-pointer entry. An allocation in the flush cycle is neither granted nor stalled.
- R11: A ready read also returns the physical register tag stored at allocation on `rd_ptag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request |
| alloc_pool | input | 1 | Pool select: 0 general, 1 stack-pointer |
| alloc_ptag | input | PTW | Physical tag recorded in the new entry |
| alloc_gnt | output | 1 | Allocation granted this cycle |
| alloc_idx | output | IDX_W | Index of the granted entry |
| alloc_stall | output | 1 | Requested pool is full |
| wr_en | input | 1 | Completion write strobe |
| wr_idx | input | IDX_W | Entry written |
| wr_data | input | DW | Produced value |
| rd_en | input | NRD | Per-port read strobe |
| rd_idx | input | NRD*IDX_W | Per-port entry index |
| rd_ready | output | NRD | Per-port operand available |
| rd_data | output | NRD*DW | Per-port operand value |
| rd_ptag | output | NRD*PTW | Per-port stored physical tag |
| cmt_en | input | 1 | Stack-pointer producer commits |
| cmt_idx | input | IDX_W | Entry of the committing producer |
| flush | input | 1 | Pipeline flush |

## Verification
Grant, stall and read results are combinational on the current state. The bench drives inputs one time unit after a rising edge and the monitor compares them at the following falling edge, in the same cycle. Writes, releases, commits and flushes change state at the next rising edge, so their effect is checked by a read or allocation placed in the step after them. Every expectation is queued in the same step that drives its stimulus, which ties each result to one cycle.

// File: rtl/ropb_pkg.sv
package ropb_pkg;
    localparam int SP_ENTRIES = 2;

    typedef enum logic {
        POOL_GEN = 1'b0,
        POOL_SP  = 1'b1
    } pool_e;
endpackage

// File: rtl/ropb_pick.sv
// Lowest-index free entry finder
module ropb_pick #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] free_vec,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/ropb_rdport.sv
// One read port with same-cycle forwarding from the completion write
module ropb_rdport #(
    parameter int NENT  = 6,
    parameter int IDX_W = 3,
    parameter int DW    = 32,
    parameter int PTW   = 7
) (
    input  logic                      rd_en,
    input  logic [IDX_W-1:0]          rd_idx,
    input  logic [NENT-1:0]           ent_valid,
    input  logic [NENT-1:0]           ent_ready,
    input  logic [NENT-1:0][DW-1:0]   ent_data,
    input  logic [NENT-1:0][PTW-1:0]  ent_ptag,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DW-1:0]             wr_data,
    output logic                      rdy,
    output logic [DW-1:0]             data,
    output logic [PTW-1:0]            ptag
);
    logic          hit_v;
    logic          hit_r;
    logic [DW-1:0] hit_d;
    logic          fwd;

    always_comb begin
        hit_v = 1'b0;
        hit_r = 1'b0;
        hit_d = '0;
        ptag  = '0;
        for (int e = 0; e < NENT; e++) begin
            if (rd_idx == IDX_W'(e)) begin
                hit_v = ent_valid[e];
                hit_r = ent_ready[e];
                hit_d = ent_data[e];
                ptag  = ent_ptag[e];
            end
        end
        fwd  = wr_en && (wr_idx == rd_idx);
        rdy  = rd_en && hit_v && (hit_r || fwd);
        data = fwd ? wr_data : hit_d;
    end
endmodule

// File: rtl/remote_opnd_buf.sv
module remote_opnd_buf #(
    parameter int NGEN  = 4,
    parameter int NRD   = 2,
    parameter int DW    = 32,
    parameter int PTW   = 7,
    localparam int NSP   = ropb_pkg::SP_ENTRIES,
    localparam int NENT  = NGEN + NSP,
    localparam int IDX_W = $clog2(NENT)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      alloc_req,
    input  logic                      alloc_pool,
    input  logic [PTW-1:0]            alloc_ptag,
    output logic                      alloc_gnt,
    output logic [IDX_W-1:0]          alloc_idx,
    output logic                      alloc_stall,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [DW-1:0]             wr_data,
    input  logic [NRD-1:0]            rd_en,
    input  logic [NRD-1:0][IDX_W-1:0] rd_idx,
    output logic [NRD-1:0]            rd_ready,
    output logic [NRD-1:0][DW-1:0]    rd_data,
    output logic [NRD-1:0][PTW-1:0]   rd_ptag,
    input  logic                      cmt_en,
    input  logic [IDX_W-1:0]          cmt_idx,
    input  logic                      flush
);
    localparam int GW = (NGEN > 1) ? $clog2(NGEN) : 1;
    localparam int SW = (NSP > 1) ? $clog2(NSP) : 1;

    typedef struct packed {
        logic [NENT-1:0]          valid;
        logic [NENT-1:0]          ready;
        logic [NSP-1:0]           cmt;
        logic [NENT-1:0][PTW-1:0] ptag;
        logic [NENT-1:0][DW-1:0]  data;
    } state_t;

    state_t s_q, s_d;

    logic          gen_found, sp_found;
    logic [GW-1:0] gen_idx;
    logic [SW-1:0] sp_idx;
    logic          pool_found;

    ropb_pick #(.N(NGEN), .W(GW)) i_pick_gen (
        .free_vec (~s_q.valid[NGEN-1:0]),
        .found    (gen_found),
        .idx      (gen_idx)
    );

    ropb_pick #(.N(NSP), .W(SW)) i_pick_sp (
        .free_vec (~s_q.valid[NENT-1:NGEN]),
        .found    (sp_found),
        .idx      (sp_idx)
    );

    assign pool_found  = (alloc_pool == ropb_pkg::POOL_SP) ? sp_found : gen_found;
    assign alloc_gnt   = alloc_req && !flush && pool_found;
    assign alloc_stall = alloc_req && !flush && !pool_found;
    assign alloc_idx   = (alloc_pool == ropb_pkg::POOL_SP)
                       ? IDX_W'(NGEN) + IDX_W'(sp_idx)
                       : IDX_W'(gen_idx);

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        ropb_rdport #(.NENT(NENT), .IDX_W(IDX_W), .DW(DW), .PTW(PTW)) i_port (
            .rd_en     (rd_en[p]),
            .rd_idx    (rd_idx[p]),
            .ent_valid (s_q.valid),
            .ent_ready (s_q.ready),
            .ent_data  (s_q.data),
            .ent_ptag  (s_q.ptag),
            .wr_en     (wr_en),
            .wr_idx    (wr_idx),
            .wr_data   (wr_data),
            .rdy       (rd_ready[p]),
            .data      (rd_data[p]),
            .ptag      (rd_ptag[p])
        );
    end

    always_comb begin
        s_d = s_q;

        // completion write: only a live entry accepts it
        for (int e = 0; e < NENT; e++) begin
            if (wr_en && wr_idx == IDX_W'(e) && s_q.valid[e]) begin
                s_d.ready[e] = 1'b1;
                s_d.data[e]  = wr_data;
            end
        end

        // single-consumer release of general entries
        for (int e = 0; e < NGEN; e++) begin
            for (int p = 0; p < NRD; p++) begin
                if (rd_ready[p] && rd_idx[p] == IDX_W'(e)) begin
                    s_d.valid[e] = 1'b0;
                    s_d.ready[e] = 1'b0;
                end
            end
        end

        // stack-pointer commit retires the older committed copy
        for (int s = 0; s < NSP; s++) begin
            if (cmt_en && cmt_idx == IDX_W'(NGEN + s) && s_q.valid[NGEN + s]) begin
                s_d.cmt[s] = 1'b1;
                for (int k = 0; k < NSP; k++) begin
                    if (k != s && s_q.cmt[k]) begin
                        s_d.valid[NGEN + k] = 1'b0;
                        s_d.ready[NGEN + k] = 1'b0;
                        s_d.cmt[k]          = 1'b0;
                    end
                end
            end
        end

        // allocation claims a free entry
        if (alloc_gnt) begin
            for (int e = 0; e < NENT; e++) begin
                if (alloc_idx == IDX_W'(e)) begin
                    s_d.valid[e] = 1'b1;
                    s_d.ready[e] = 1'b0;
                    s_d.ptag[e]  = alloc_ptag;
                end
            end
            for (int s = 0; s < NSP; s++) begin
                if (alloc_idx == IDX_W'(NGEN + s)) begin
                    s_d.cmt[s] = 1'b0;
                end
            end
        end

        // flush keeps only the committed stack-pointer copy
        if (flush) begin
            for (int e = 0; e < NGEN; e++) begin
                s_d.valid[e] = 1'b0;
                s_d.ready[e] = 1'b0;
            end
            for (int s = 0; s < NSP; s++) begin
                if (!s_d.cmt[s]) begin
                    s_d.valid[NGEN + s] = 1'b0;
                    s_d.ready[NGEN + s] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/ropb_chk.sv
module ropb_chk #(
    parameter int NGEN  = 4,
    parameter int DW    = 32,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_req,
    input logic             alloc_pool,
    input logic             alloc_gnt,
    input logic [IDX_W-1:0] alloc_idx,
    input logic             alloc_stall,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [DW-1:0]    wr_data,
    input logic             rd_en0,
    input logic [IDX_W-1:0] rd_idx0,
    input logic             rd_ready0,
    input logic [DW-1:0]    rd_data0,
    input logic             cmt_en,
    input logic             flush
);
    assert_pool_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |-> (alloc_pool ? (alloc_idx >= IDX_W'(NGEN)) : (alloc_idx < IDX_W'(NGEN))));

    assert_stall_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_stall && !alloc_pool && rd_en0 && rd_ready0 && rd_idx0 < IDX_W'(NGEN) && !flush)
        |=> !(alloc_req && !alloc_pool) || !alloc_stall);

    assert_forward_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en0 && rd_ready0 && wr_en && wr_idx == rd_idx0) |-> rd_data0 == wr_data);

    assert_gen_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en0 && rd_ready0 && rd_idx0 < IDX_W'(NGEN))
        |=> !(rd_en0 && rd_idx0 == $past(rd_idx0)) || !rd_ready0);

    assert_sp_retained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en0 && rd_ready0 && rd_idx0 >= IDX_W'(NGEN) && !cmt_en && !flush)
        |=> !(rd_en0 && rd_idx0 == $past(rd_idx0)) || rd_ready0);

    assert_flush_gen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !(rd_en0 && rd_idx0 < IDX_W'(NGEN)) || !rd_ready0);

    assert_flush_no_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !alloc_gnt && !alloc_stall);
endmodule

bind remote_opnd_buf ropb_chk #(.NGEN(NGEN), .DW(DW), .IDX_W(IDX_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_req   (alloc_req),
    .alloc_pool  (alloc_pool),
    .alloc_gnt   (alloc_gnt),
    .alloc_idx   (alloc_idx),
    .alloc_stall (alloc_stall),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .rd_en0      (rd_en[0]),
    .rd_idx0     (rd_idx[0]),
    .rd_ready0   (rd_ready[0]),
    .rd_data0    (rd_data[0]),
    .cmt_en      (cmt_en),
    .flush       (flush)
);

// File: tb/test_remote_opnd_buf.sv
module test_remote_opnd_buf;
    localparam int CLK_PERIOD = 10;
    localparam int NGEN  = 4;
    localparam int NRD   = 2;
    localparam int DW    = 16;
    localparam int PTW   = 6;
    localparam int IDX_W = 3;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      alloc_req, alloc_pool;
    logic [PTW-1:0]            alloc_ptag;
    logic                      alloc_gnt, alloc_stall;
    logic [IDX_W-1:0]          alloc_idx;
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;
    logic [DW-1:0]             wr_data;
    logic [NRD-1:0]            rd_en;
    logic [NRD-1:0][IDX_W-1:0] rd_idx;
    logic [NRD-1:0]            rd_ready;
    logic [NRD-1:0][DW-1:0]    rd_data;
    logic [NRD-1:0][PTW-1:0]   rd_ptag;
    logic                      cmt_en;
    logic [IDX_W-1:0]          cmt_idx;
    logic                      flush;

    int checks = 0;
    int errors = 0;

    typedef struct {
        bit             is_alloc;
        int             port;
        logic           rdy;
        logic [DW-1:0]  data;
        logic [PTW-1:0] ptag;
        logic           gnt;
        logic [IDX_W-1:0] idx;
        logic           stall;
        string          tag;
    } item_t;

    item_t sb[$];

    remote_opnd_buf #(.NGEN(NGEN), .NRD(NRD), .DW(DW), .PTW(PTW)) i_remote_opnd_buf (
        .clk(clk), .rst_n(rst_n),
        .alloc_req(alloc_req), .alloc_pool(alloc_pool), .alloc_ptag(alloc_ptag),
        .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx), .alloc_stall(alloc_stall),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_ready(rd_ready),
        .rd_data(rd_data), .rd_ptag(rd_ptag),
        .cmt_en(cmt_en), .cmt_idx(cmt_idx), .flush(flush)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic clear_in();
        alloc_req = 0; alloc_pool = 0; alloc_ptag = '0;
        wr_en = 0; wr_idx = '0; wr_data = '0;
        rd_en = '0; rd_idx = '0;
        cmt_en = 0; cmt_idx = '0; flush = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_in();
    endtask

    task automatic rd(int p, int idx);
        rd_en[p]  = 1'b1;
        rd_idx[p] = IDX_W'(idx);
    endtask

    task automatic al(bit pool, int ptag);
        alloc_req  = 1'b1;
        alloc_pool = pool;
        alloc_ptag = PTW'(ptag);
    endtask

    task automatic wr(int idx, int data);
        wr_en   = 1'b1;
        wr_idx  = IDX_W'(idx);
        wr_data = DW'(data);
    endtask

    task automatic exp_rd(int p, bit rdy, int data, int ptag, string tag);
        item_t it;
        it.is_alloc = 0; it.port = p; it.rdy = rdy;
        it.data = DW'(data); it.ptag = PTW'(ptag);
        it.gnt = 0; it.idx = '0; it.stall = 0; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic exp_al(bit gnt, int idx, bit stall, string tag);
        item_t it;
        it.is_alloc = 1; it.port = 0; it.rdy = 0; it.data = '0; it.ptag = '0;
        it.gnt = gnt; it.idx = IDX_W'(idx); it.stall = stall; it.tag = tag;
        sb.push_back(it);
    endtask

    // monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (it.is_alloc) begin
                if (alloc_gnt !== it.gnt || alloc_stall !== it.stall ||
                    (it.gnt && alloc_idx !== it.idx)) begin
                    errors++;
                    $display("FAIL %s alloc: gnt=%0b idx=%0d stall=%0b expected gnt=%0b idx=%0d stall=%0b",
                             it.tag, alloc_gnt, alloc_idx, alloc_stall, it.gnt, it.idx, it.stall);
                end
            end else begin
                if (rd_ready[it.port] !== it.rdy ||
                    (it.rdy && (rd_data[it.port] !== it.data || rd_ptag[it.port] !== it.ptag))) begin
                    errors++;
                    $display("FAIL %s read port %0d: rdy=%0b data=%h ptag=%0d expected rdy=%0b data=%h ptag=%0d",
                             it.tag, it.port, rd_ready[it.port], rd_data[it.port], rd_ptag[it.port],
                             it.rdy, it.data, it.ptag);
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: cycles=2000 expected completion earlier");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R1: empty after reset
        rd(0, 0); rd(1, 4); exp_rd(0, 0, 0, 0, "R1"); exp_rd(1, 0, 0, 0, "R1");
        al(0, 5); exp_al(1, 0, 0, "R1");
        tick();
        // R2: next general index
        al(0, 7); exp_al(1, 1, 0, "R2");
        rd(0, 0); exp_rd(0, 0, 0, 0, "R4");
        tick();
        // R4: unready read did not release; R2 stack-pointer pool
        rd(0, 0); exp_rd(0, 0, 0, 0, "R4");
        al(1, 9); exp_al(1, 4, 0, "R2");
        tick();
        // R6: forwarding on same-cycle write
        wr(0, 'hA1); rd(0, 0); exp_rd(0, 1, 'hA1, 5, "R6");
        tick();
        // R7: released; R5 write to free entry
        rd(0, 0); exp_rd(0, 0, 0, 0, "R7");
        wr(3, 'h33);
        tick();
        rd(1, 3); exp_rd(1, 0, 0, 0, "R5");
        wr(1, 'hB2);
        tick();
        // R5 + R11: stored value and tag
        rd(0, 1); exp_rd(0, 1, 'hB2, 7, "R11");
        tick();
        // fill the general pool
        for (int i = 0; i < 4; i++) begin
            al(0, 10 + i); exp_al(1, i, 0, "R2");
            tick();
        end
        // R3: full pool stalls
        al(0, 20); exp_al(0, 0, 1, "R3");
        wr(2, 'hC3);
        tick();
        al(0, 20); exp_al(0, 0, 1, "R3");
        rd(1, 2); exp_rd(1, 1, 'hC3, 12, "R7");
        tick();
        al(0, 14); exp_al(1, 2, 0, "R3");
        tick();
        // R8: stack-pointer retention
        wr(4, 'h05F0);
        tick();
        rd(0, 4); rd(1, 4);
        exp_rd(0, 1, 'h05F0, 9, "R8"); exp_rd(1, 1, 'h05F0, 9, "R8");
        tick();
        rd(0, 4); exp_rd(0, 1, 'h05F0, 9, "R8");
        cmt_en = 1; cmt_idx = 3'd4;
        tick();
        al(1, 21); exp_al(1, 5, 0, "R2");
        tick();
        al(1, 22); exp_al(0, 0, 1, "R3");
        rd(0, 4); exp_rd(0, 1, 'h05F0, 9, "R8");
        tick();
        // R9: commit naming a general index is ignored
        cmt_en = 1; cmt_idx = 3'd1;
        wr(5, 'h0600);
        tick();
        rd(0, 4); exp_rd(0, 1, 'h05F0, 9, "R9");
        cmt_en = 1; cmt_idx = 3'd5;
        tick();
        rd(0, 4); exp_rd(0, 0, 0, 0, "R9");
        rd(1, 5); exp_rd(1, 1, 'h0600, 21, "R9");
        tick();
        al(1, 23); exp_al(1, 4, 0, "R9");
        tick();
        // R10: flush
        flush = 1; al(0, 30); exp_al(0, 0, 0, "R10");
        tick();
        rd(0, 5); exp_rd(0, 1, 'h0600, 21, "R10");
        rd(1, 4); exp_rd(1, 0, 0, 0, "R10");
        tick();
        rd(0, 0); rd(1, 3); exp_rd(0, 0, 0, 0, "R10"); exp_rd(1, 0, 0, 0, "R10");
        tick();
        al(0, 31); exp_al(1, 0, 0, "R10");
        tick();
        @(negedge clk);
        #1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule